// File: doc/BRIEF.md
# Sector Write Capture Sequencer

This block sits behind the flux decoder of a disk controller emulation and turns the controller's serial write stream for one sector into 16-bit words for a simple memory port. A write begins when the write gate is raised. A run of zero cells then passes, and the first one cell marks the start of a fixed five-cell synchronisation mark, `11110`. After the mark, the stream is a sequence of 20-cell words. Each word is 16 data bits sent most significant bit first, followed by four check bits.

Each assembled word is presented on a one-cycle memory write strobe, with an address that restarts at zero for each sector. The four check bits are compared against the pattern the data bits call for and are then thrown away. They never reach the data register, the bit count that feeds it, or the word address. A wrong check bit sets a sticky error flag, which is cleared only when the next write begins.

The sector ends after 321 words, or earlier if the write gate drops. The block then ignores the stream until the sector pulse returns it to idle.

Top module: `sector_write_capture`

## Requirements
- R1: After reset the block is idle, with `mem_we` and `check_err` low. While idle, and until it samples `write_gate` high, it ignores every `bit_valid` strobe.
- R2: Once the write has started, zero cells are skipped. The first one cell starts the synchronisation mark, and exactly four further cells are consumed as the rest of the mark. The cell after that is data bit 15 of word 0.
- R3: Each word occupies 20 accepted cells. The first 16 cells are shifted in most significant bit first, so the first cell becomes bit 15. `mem_we` is high for exactly one clock, in the cycle after the edge that accepts the 16th data cell, and `mem_wdata` carries the word in that cycle.
- R4: The first word of every sector is written at `mem_addr` 0. Each later word is written at the previous address plus one.
- R5: Cells 17 to 20 of a word are check bits, which are never written to memory and never advance the address. The expected pattern, in the order sent, is 0000, 1110, 1100 or 1000 when the word's count of one bits modulo 4 is 0, 1, 2 or 3. If every check bit matches, `check_err` stays low.
- R6: Any check bit that differs from the expected pattern sets `check_err`. The flag stays set through the postamble and idle. It is cleared on the clock edge at which an idle block samples `write_gate` high.
- R7: After the 321st word's last check cell the block enters the postamble. No further word is written, whatever cells follow.
- R8: If `write_gate` is low during the preamble, the synchronisation mark or the data phase, the block enters the postamble on that edge. Any partly received word is discarded.
- R9: In the postamble, cells and `write_gate` are ignored. A `sector_pulse` returns the block to idle, and the next write then begins again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| write_gate | input | 1 | High while the controller is writing the sector |
| sector_pulse | input | 1 | Start-of-sector marker; ends the postamble |
| bit_valid | input | 1 | One-clock strobe marking a decoded bit cell |
| bit_data | input | 1 | Value of the bit cell, valid with `bit_valid` |
| mem_we | output | 1 | One-clock write strobe for an assembled word |
| mem_addr | output | 9 | Word address within the sector |
| mem_wdata | output | 16 | Assembled data word |
| check_err | output | 1 | Sticky check-bit mismatch flag |

## Verification
The hardest states to reach from the ports are the far end of a full sector and the exits that happen mid-stream. Reaching word 321 takes a complete, error-free stream of more than six thousand cells, followed by trailing cells that must be ignored. The exits are a gate drop partway through a word and a gate drop during the preamble, each followed by a stream that looks valid but must write nothing. The bench generates every word's check pattern with its own counting routine, so it can send correct streams of any length. It flips a chosen check bit to force a mismatch. It then walks the error flag through the postamble, idle and the first edge of the next write, and mixes random gaps between cells and random word counts with directed words covering every ones-count residue.

// File: rtl/sector_cap_pkg.sv
package sector_cap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_SYNC = 3'd2,
    ST_DATA = 3'd3,
    ST_POST = 3'd4
  } cap_state_e;

  // Value the check cell at position idx (0 = first sent) must carry,
  // given the ones count modulo 4 of the word's data bits.
  function automatic logic chk_expect(input logic [1:0] ones, input logic [1:0] idx);
    logic [1:0] need;
    need = ~ones + 2'd1;
    return idx < need;
  endfunction

  function automatic logic [1:0] ones_step(input logic [1:0] ones, input logic b);
    return ones + {1'b0, b};
  endfunction

endpackage

// File: rtl/cap_check_tracker.sv
module cap_check_tracker
  import sector_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       data_en,
  input  logic       chk_en,
  input  logic [1:0] chk_idx,
  input  logic       word_end,
  input  logic       bit_in,
  output logic       mismatch,
  output logic       check_err
);

  logic [1:0] ones_q;

  assign mismatch = chk_en && (bit_in != chk_expect(ones_q, chk_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q    <= 2'd0;
      check_err <= 1'b0;
    end else begin
      if (clear || word_end) ones_q <= 2'd0;
      else if (data_en)      ones_q <= ones_step(ones_q, bit_in);
      if (clear)             check_err <= 1'b0;
      else if (mismatch)     check_err <= 1'b1;
    end
  end

  // R6: once set, the flag holds until a write start clears it
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    check_err && !clear |=> check_err);

  // R6: a mismatching check cell raises the flag
  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch && !clear |=> check_err);

  // R5: data cells and check cells never coincide
  p_phase_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_en && chk_en));

endmodule

// File: rtl/cap_word_assembler.sv
module cap_word_assembler #(
  parameter int DATA_BITS = 16,
  parameter int ADDR_W    = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 commit,
  input  logic                 bit_in,
  input  logic [ADDR_W-1:0]    addr_in,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_BITS-1:0] mem_wdata
);

  logic [DATA_BITS-2:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= commit;
      if (shift_en) shreg <= {shreg[DATA_BITS-3:0], bit_in};
      if (commit) begin
        mem_wdata <= {shreg, bit_in};
        mem_addr  <= addr_in;
      end
    end
  end

  // R3: the write strobe lasts exactly one clock
  p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R3: the last data cell always produces a strobe
  p_commit_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> mem_we);

endmodule

// File: rtl/sector_write_capture.sv
module sector_write_capture
  import sector_cap_pkg::*;
#(
  parameter int DATA_BITS = 16,
  parameter int MAX_WORDS = 321,
  parameter int SYNC_TAIL = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        write_gate,
  input  logic        sector_pulse,
  input  logic        bit_valid,
  input  logic        bit_data,
  output logic        mem_we,
  output logic [8:0]  mem_addr,
  output logic [15:0] mem_wdata,
  output logic        check_err
);

  localparam int CHECK_BITS = 4;
  localparam int CELLS      = DATA_BITS + CHECK_BITS;
  localparam int CNT_W      = $clog2(CELLS);
  localparam int ADDR_W     = $clog2(MAX_WORDS);
  localparam int SC_W       = $clog2(SYNC_TAIL + 1);

  cap_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] word_cnt;
  logic [SC_W-1:0]   sync_cnt;

  // named internal events
  logic start_write, gate_lost, cell_in, in_data_part;
  logic data_en, commit, chk_en, word_end, last_word, mismatch;
  logic [1:0] chk_idx;

  assign start_write  = (state == ST_IDLE) && write_gate;
  assign gate_lost    = (state == ST_PRE || state == ST_SYNC || state == ST_DATA) && !write_gate;
  assign cell_in      = (state == ST_DATA) && write_gate && bit_valid;
  assign in_data_part = bit_cnt < CNT_W'(DATA_BITS);
  assign data_en      = cell_in && in_data_part;
  assign commit       = cell_in && (bit_cnt == CNT_W'(DATA_BITS - 1));
  assign chk_en       = cell_in && !in_data_part;
  assign chk_idx      = 2'(bit_cnt - CNT_W'(DATA_BITS));
  assign word_end     = cell_in && (bit_cnt == CNT_W'(CELLS - 1));
  assign last_word    = word_end && (word_cnt == ADDR_W'(MAX_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      word_cnt <= '0;
      sync_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (write_gate) begin
          state    <= ST_PRE;
          bit_cnt  <= '0;
          word_cnt <= '0;
        end
        ST_PRE: begin
          if (!write_gate) state <= ST_POST;
          else if (bit_valid && bit_data) begin
            state    <= ST_SYNC;
            sync_cnt <= '0;
          end
        end
        ST_SYNC: begin
          if (!write_gate) state <= ST_POST;
          else if (bit_valid) begin
            if (sync_cnt == SC_W'(SYNC_TAIL - 1)) begin
              state   <= ST_DATA;
              bit_cnt <= '0;
            end else begin
              sync_cnt <= sync_cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (!write_gate) state <= ST_POST;
          else if (bit_valid) begin
            if (word_end) begin
              bit_cnt  <= '0;
              word_cnt <= word_cnt + 1'b1;
              if (last_word) state <= ST_POST;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_POST: if (sector_pulse) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  cap_check_tracker u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_write),
    .data_en   (data_en),
    .chk_en    (chk_en),
    .chk_idx   (chk_idx),
    .word_end  (word_end),
    .bit_in    (bit_data),
    .mismatch  (mismatch),
    .check_err (check_err)
  );

  cap_word_assembler #(
    .DATA_BITS (DATA_BITS),
    .ADDR_W    (ADDR_W)
  ) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (data_en),
    .commit    (commit),
    .bit_in    (bit_data),
    .addr_in   (word_cnt),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // R1: idle holds while the gate is low
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && !write_gate |=> (state == ST_IDLE));

  // R8: a lost gate ends the sector on the next edge
  p_gate_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_lost |=> (state == ST_POST));

  // R7: the final word leads to the postamble
  p_last_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> (state == ST_POST));

  // R9: sector pulse closes the postamble
  p_post_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POST) && sector_pulse |=> (state == ST_IDLE));

  // R9: nothing is written once in the postamble
  p_post_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POST) |=> !mem_we);

  // R6: a write start clears the error flag
  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_write |=> !check_err);

  // R4: addresses stay inside the sector
  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr <= 9'(MAX_WORDS - 1)));

  // R2: the mark tail is only counted while in the mark state
  p_sync_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SYNC) |-> (sync_cnt < SC_W'(SYNC_TAIL)));

endmodule

// File: tb/tb_sector_write_capture.sv
module tb_sector_write_capture;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        write_gate = 1'b0;
  logic        sector_pulse = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_data = 1'b0;
  logic        mem_we;
  logic [8:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        check_err;

  int total = 0;
  int bad   = 0;
  int log_n = 0;
  logic [8:0]  log_addr [0:1023];
  logic [15:0] log_data [0:1023];
  logic [15:0] exp_w    [0:399];

  always #10 clk = ~clk;

  sector_write_capture dut (
    .clk(clk), .rst_n(rst_n), .write_gate(write_gate), .sector_pulse(sector_pulse),
    .bit_valid(bit_valid), .bit_data(bit_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .check_err(check_err)
  );

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (log_n < 1024) begin
        log_addr[log_n] = mem_addr;
        log_data[log_n] = mem_wdata;
      end
      log_n = log_n + 1;
    end
  end

  function automatic logic [3:0] bench_check(input logic [15:0] w);
    int c;
    logic [3:0] p;
    c = $countones(w) % 4;
    p = 4'b0000;
    for (int k = 3; k >= 0; k--) begin
      if (c != 0) begin
        p[k] = 1'b1;
        c = (c + 1) % 4;
      end
    end
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int gap);
    bit_valid = 1'b1;
    bit_data  = b;
    @(negedge clk);
    bit_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_rnd(input logic b);
    send_bit(b, $urandom_range(2));
  endtask

  task automatic send_word(input logic [15:0] w, input bit corrupt);
    logic [3:0] p;
    p = bench_check(w);
    if (corrupt) p[$urandom_range(3)] ^= 1'b1;
    for (int i = 15; i >= 0; i--) send_rnd(w[i]);
    for (int i = 3; i >= 0; i--) send_rnd(p[i]);
  endtask

  task automatic send_mark();
    send_rnd(1'b1); send_rnd(1'b1); send_rnd(1'b1); send_rnd(1'b1); send_rnd(1'b0);
  endtask

  task automatic begin_sector(input int npre);
    write_gate = 1'b1;
    for (int i = 0; i < npre; i++) send_rnd(1'b0);
    send_mark();
  endtask

  task automatic end_sector();
    write_gate = 1'b0;
    @(negedge clk);
    sector_pulse = 1'b1;
    @(negedge clk);
    sector_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_log(input int base, input int n, input string req);
    #1;
    chk(log_n - base == n, req, "word count", log_n - base, n);
    for (int i = 0; i < n && base + i < 1024; i++) begin
      chk(log_addr[base+i] == 9'(i), "R4", "address", int'(log_addr[base+i]), i);
      chk(log_data[base+i] == exp_w[i], req, "data", int'(log_data[base+i]), int'(exp_w[i]));
    end
  endtask

  task automatic run_all();
    int base;
    int n;
    int bad_idx;
    logic [15:0] dir [0:6];
    dir[0] = 16'h0000; dir[1] = 16'hFFFF; dir[2] = 16'h0001; dir[3] = 16'h8000;
    dir[4] = 16'h0003; dir[5] = 16'h0007; dir[6] = 16'hA5C3;

    repeat (4) @(negedge clk);
    chk(mem_we == 1'b0, "R1", "reset mem_we", int'(mem_we), 0);
    chk(check_err == 1'b0, "R1", "reset check_err", int'(check_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: stream with gate low is ignored
    base = log_n;
    send_mark();
    send_word(16'h1234, 1'b0);
    for (int i = 0; i < 30; i++) send_rnd(1'($urandom_range(1)));
    #1 chk(log_n == base, "R1", "writes while idle", log_n - base, 0);

    // R2 R3 R5: directed words covering all residues
    base = log_n;
    begin_sector(6);
    for (int i = 0; i < 7; i++) begin exp_w[i] = dir[i]; send_word(dir[i], 1'b0); end
    end_sector();
    check_log(base, 7, "R3");
    chk(check_err == 1'b0, "R5", "clean check bits", int'(check_err), 0);

    // R3: strobe timing at the 16th data cell
    base = log_n;
    begin_sector(4);
    for (int i = 15; i >= 1; i--) send_bit(16'hC35A >> i, 0);
    chk(mem_we == 1'b0, "R3", "no strobe before 16th cell", int'(mem_we), 0);
    send_bit(1'b0, 0);
    chk(mem_we == 1'b1, "R3", "strobe after 16th cell", int'(mem_we), 1);
    chk(mem_wdata == 16'hC35A, "R3", "strobe data", int'(mem_wdata), 'hC35A);
    chk(mem_addr == 9'd0, "R4", "first address", int'(mem_addr), 0);
    send_bit(bench_check(16'hC35A) >> 3, 0);
    chk(mem_we == 1'b0, "R3", "strobe one clock", int'(mem_we), 0);
    send_bit(bench_check(16'hC35A) >> 2, 0);
    send_bit(bench_check(16'hC35A) >> 1, 0);
    send_bit(bench_check(16'hC35A), 0);
    end_sector();
    chk(check_err == 1'b0, "R5", "timing sector clean", int'(check_err), 0);

    // R6: mismatch sets sticky flag, cleared at next write start
    base = log_n;
    begin_sector(5);
    for (int i = 0; i < 3; i++) begin
      exp_w[i] = 16'($urandom);
      send_word(exp_w[i], i == 1);
    end
    write_gate = 1'b0;
    @(negedge clk);
    chk(check_err == 1'b1, "R6", "flag after bad check bit", int'(check_err), 1);
    check_log(base, 3, "R5");
    end_sector();
    chk(check_err == 1'b1, "R6", "flag held in idle", int'(check_err), 1);
    write_gate = 1'b1;
    @(negedge clk);
    chk(check_err == 1'b0, "R6", "flag cleared at write start", int'(check_err), 0);
    end_sector();

    // R7: full sector then trailing cells
    base = log_n;
    begin_sector(8);
    for (int i = 0; i < 321; i++) begin exp_w[i] = 16'($urandom); send_word(exp_w[i], 1'b0); end
    for (int i = 0; i < 45; i++) send_rnd(1'($urandom_range(1)));
    check_log(base, 321, "R7");
    chk(check_err == 1'b0, "R7", "full sector clean", int'(check_err), 0);
    end_sector();

    // R8 R9: gate drop mid-word, postamble ignores a valid-looking stream
    base = log_n;
    begin_sector(5);
    for (int i = 0; i < 2; i++) begin exp_w[i] = 16'($urandom); send_word(exp_w[i], 1'b0); end
    for (int i = 0; i < 10; i++) send_rnd(1'b1);
    write_gate = 1'b0;
    @(negedge clk);
    write_gate = 1'b1;
    for (int i = 0; i < 4; i++) send_rnd(1'b0);
    send_mark();
    send_word(16'h5555, 1'b0);
    check_log(base, 2, "R8");
    base = log_n;
    sector_pulse = 1'b1;
    @(negedge clk);
    sector_pulse = 1'b0;
    for (int i = 0; i < 4; i++) send_rnd(1'b0);
    send_mark();
    exp_w[0] = 16'h0F0F;
    send_word(exp_w[0], 1'b0);
    check_log(base, 1, "R9");
    end_sector();

    // R8: gate drop during the preamble
    base = log_n;
    write_gate = 1'b1;
    for (int i = 0; i < 5; i++) send_rnd(1'b0);
    write_gate = 1'b0;
    @(negedge clk);
    write_gate = 1'b1;
    send_mark();
    send_word(16'h00FF, 1'b0);
    #1 chk(log_n == base, "R8", "no writes after preamble drop", log_n - base, 0);
    end_sector();

    // R2 R3 R4 R6: random sectors
    for (int s = 0; s < 20; s++) begin
      base = log_n;
      n = $urandom_range(1, 10);
      bad_idx = ($urandom_range(4) == 0) ? int'($urandom_range(n - 1)) : -1;
      begin_sector($urandom_range(2, 12));
      for (int i = 0; i < n; i++) begin
        exp_w[i] = 16'($urandom);
        send_word(exp_w[i], i == bad_idx);
      end
      end_sector();
      check_log(base, n, "R2");
      chk(check_err == (bad_idx >= 0), "R6", "random sector flag", int'(check_err), int'(bad_idx >= 0));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule